// File: doc/BRIEF.md
# PHY Station Management Register

This block models the station-control register through which a host reaches a bank of 32 emulated 16-bit PHY registers, without any serial management engine behind it. The host sees the 32-bit register as two 16-bit slots on a narrow bus. The data slot (half select low) carries bits 31:16 of the command word. The control slot (half select high) carries bits 15:0. Writing the data slot only stages a value. Writing the control slot commits the command formed by the staged data slot and the new control halfword, and the PHY bank access happens in that same cycle.

A read command fetches the addressed PHY register into the data slot. While the link input is high, the block ORs link, speed, duplex and autonegotiation status into the two status registers on the way out. A write command stores the data slot into the addressed register. Writes to the basic control register have their self-clearing reset bit removed. Both kinds of command leave an operation-complete flag set in the control slot until the next commit. A host then reads either slot back through a registered read port.

Top module: `phy_sta_reg`

## Requirements
- R1: After reset, both slots read back as 0x0000.
- R2: A write to the data slot (bus_hi=0) stores the halfword there and changes neither the control slot nor any PHY register.
- R3: A write to the control slot (bus_hi=1) commits a command. Control bits: [4:0] register address, [13] read, [14] write, [15] operation complete. The data slot holds bits 31:16 of the command.
- R4: A read command loads the addressed PHY register into the data slot. The control slot becomes the written halfword with bit 15 set.
- R5: With link_up high, a read of register 1 returns its stored value OR 0x0024 (bit 2 link up, bit 5 autonegotiation done).
- R6: With link_up high, a read of register 16 returns its stored value OR 0x0017 (bit 0 link, bit 1 100 Mb/s, bit 2 full duplex, bit 4 autonegotiation done). With link_up low, no bits are merged into any register.
- R7: A write command stores the data slot into the addressed register. The control slot becomes the written halfword with bit 15 set, and the data slot is left as it was.
- R8: A write to register 0 is stored with bit 15 cleared and bit 0 set.
- R9: A command with neither read nor write set stores the control halfword exactly as written and changes no PHY register.
- R10: A command with both bits set performs the read first (merged value into the data slot) and then stores that value into the same register, with R8 applied.
- R11: bus_rdata takes the selected slot one cycle after bus_rd is high and holds its value in every cycle without bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Halfword write strobe |
| bus_rd | input | 1 | Halfword read strobe |
| bus_hi | input | 1 | Slot select: 0 data slot, 1 control slot |
| bus_wdata | input | 16 | Write halfword |
| link_up | input | 1 | Live link status merged into status reads |
| bus_rdata | output | 16 | Registered readback halfword |

## Verification
A wrong PHY bank entry or a bad address decode stays hidden until a later read command selects that register. The error then shows in the data slot one cycle after the next slot read. For that reason every register is written with a distinct pattern and then read back under both link states. A bad commit decode, such as a lost complete flag or a staged halfword taken at the wrong time, shows in the very next readback of the control or data slot. A misapplied status merge or control-register rule shows only for registers 0, 1 and 16, so those addresses are checked bit by bit against arithmetic expectations.

// File: rtl/phy_sta_pkg.sv
package phy_sta_pkg;
  localparam int unsigned SLOT_W   = 16;
  localparam int unsigned RD_BIT   = 13;
  localparam int unsigned WR_BIT   = 14;
  localparam int unsigned DONE_BIT = 15;
endpackage

// File: rtl/phy_reg_bank.sv
module phy_reg_bank #(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 5,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned CTRL_RST  = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (rst)
    (we && addr == AW'(CTRL_ADDR)) |-> (!wdata[CTRL_RST] && wdata[0])) // R8
    else $error("control register stored with reset bit or without bit 0");
endmodule

// File: rtl/phy_status_merge.sv
module phy_status_merge #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 5,
  parameter int unsigned BSR_ADDR = 1,
  parameter int unsigned VSR_ADDR = 16,
  parameter logic [DW-1:0] BSR_OR = 16'h0024,
  parameter logic [DW-1:0] VSR_OR = 16'h0017
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] raw,
  input  logic          link_up,
  output logic [DW-1:0] merged
);
  always_comb begin
    merged = raw;
    if (link_up && addr == AW'(BSR_ADDR)) merged = raw | BSR_OR;
    if (link_up && addr == AW'(VSR_ADDR)) merged = raw | VSR_OR;
  end
endmodule

// File: rtl/phy_sta_cmd.sv
module phy_sta_cmd
  import phy_sta_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned CTRL_RST  = 15,
  parameter int unsigned BSR_ADDR  = 1,
  parameter logic [SLOT_W-1:0] BSR_OR = 16'h0024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [SLOT_W-1:0] wdata,
  input  logic              link_up,
  input  logic [SLOT_W-1:0] rd_merged,
  output logic [AW-1:0]     bank_addr,
  output logic              bank_we,
  output logic [SLOT_W-1:0] bank_wdata,
  output logic [SLOT_W-1:0] data_q,
  output logic [SLOT_W-1:0] ctl_q
);
  logic              is_rd, is_wr;
  logic [SLOT_W-1:0] new_data, new_ctl;

  assign is_rd     = wdata[RD_BIT];
  assign is_wr     = wdata[WR_BIT];
  assign bank_addr = wdata[AW-1:0];

  always_comb begin
    new_data = is_rd ? rd_merged : data_q;
    new_ctl  = wdata;
    if (is_rd || is_wr) new_ctl[DONE_BIT] = 1'b1;
    bank_wdata = new_data;
    if (bank_addr == AW'(CTRL_ADDR)) begin
      bank_wdata[CTRL_RST] = 1'b0;
      bank_wdata[0]        = 1'b1;
    end
  end

  assign bank_we = wr_hi && is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ctl_q  <= '0;
    end else if (wr_lo) begin
      data_q <= wdata;
    end else if (wr_hi) begin
      data_q <= new_data;
      ctl_q  <= new_ctl;
    end
  end

  AST_LOW_KEEPS_CTL: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> $stable(ctl_q)) // R2
    else $error("data slot write disturbed control slot");

  AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && (wdata[RD_BIT] || wdata[WR_BIT])) |=> ctl_q[DONE_BIT]) // R4
    else $error("complete flag missing after command");

  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && wdata[WR_BIT] && !wdata[RD_BIT]) |=> $stable(data_q)) // R7
    else $error("write command altered data slot");

  AST_BSR_MERGE: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && wdata[RD_BIT] && link_up && wdata[AW-1:0] == AW'(BSR_ADDR))
      |=> ((data_q & BSR_OR) == BSR_OR)) // R5
    else $error("status merge missing on basic status read");
endmodule

// File: rtl/phy_sta_reg.sv
module phy_sta_reg
  import phy_sta_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned CTRL_RST  = 15,
  parameter int unsigned BSR_ADDR  = 1,
  parameter int unsigned VSR_ADDR  = 16,
  parameter logic [SLOT_W-1:0] BSR_OR = 16'h0024,
  parameter logic [SLOT_W-1:0] VSR_OR = 16'h0017
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_hi,
  input  logic [SLOT_W-1:0] bus_wdata,
  input  logic              link_up,
  output logic [SLOT_W-1:0] bus_rdata
);
  logic              wr_lo, wr_hi, bank_we;
  logic [AW-1:0]     bank_addr;
  logic [SLOT_W-1:0] bank_wdata, bank_rdata, rd_merged, data_q, ctl_q;

  assign wr_lo = bus_wr && !bus_hi;
  assign wr_hi = bus_wr &&  bus_hi;

  phy_reg_bank #(.DW(SLOT_W), .AW(AW), .CTRL_ADDR(CTRL_ADDR), .CTRL_RST(CTRL_RST)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .addr(bank_addr),
    .wdata(bank_wdata), .rdata(bank_rdata)
  );

  phy_status_merge #(.DW(SLOT_W), .AW(AW), .BSR_ADDR(BSR_ADDR), .VSR_ADDR(VSR_ADDR),
                     .BSR_OR(BSR_OR), .VSR_OR(VSR_OR)) u_merge (
    .addr(bank_addr), .raw(bank_rdata), .link_up(link_up), .merged(rd_merged)
  );

  phy_sta_cmd #(.AW(AW), .CTRL_ADDR(CTRL_ADDR), .CTRL_RST(CTRL_RST),
                .BSR_ADDR(BSR_ADDR), .BSR_OR(BSR_OR)) u_cmd (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
    .link_up(link_up), .rd_merged(rd_merged), .bank_addr(bank_addr),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .data_q(data_q), .ctl_q(ctl_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_hi ? ctl_q : data_q;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)) // R11
    else $error("readback changed without read strobe");
endmodule

// File: tb/sim_phy_sta_reg.sv
module sim_phy_sta_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_hi = 1'b0, link_up = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;
  logic [15:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_sta_reg u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_hi(bus_hi),
    .bus_wdata(bus_wdata), .link_up(link_up), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %04h expected %04h", req, act, exp);
    end
  endtask

  task automatic put(input logic hi, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_hi = hi; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic get(input logic hi, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_hi = hi;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [15:0] merge_exp(input int a, input logic [15:0] v, input logic lk);
    if (lk && a == 1)  return v | 16'h0024;
    if (lk && a == 16) return v | 16'h0017;
    return v;
  endfunction

  function automatic logic [15:0] store_exp(input int a, input logic [15:0] v);
    if (a == 0) return (v & 16'h7FFE) | 16'h0001;
    return v;
  endfunction

  function automatic string tag_of(input int a, input logic lk);
    if (a == 0) return "R8";
    if (lk && a == 1) return "R5";
    if (a == 16) return "R6";
    return "R4";
  endfunction

  initial begin
    logic [15:0] r, pat, held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    get(1'b0, r); chk("R1 data slot", r, 16'h0000);
    get(1'b1, r); chk("R1 ctl slot", r, 16'h0000);

    for (int a = 0; a < 32; a++) begin
      pat = 16'(a * 16'h0801) ^ 16'h5A3C;
      if (a == 0) pat = 16'h8000;
      put(1'b0, pat);
      put(1'b1, 16'h4000 | 16'(a));
      model[a] = store_exp(a, pat);
      get(1'b1, r); chk("R7 ctl after write", r, 16'hC000 | 16'(a));
      get(1'b0, r); chk("R7 data kept", r, pat);
    end

    for (int lk = 0; lk < 2; lk++) begin
      link_up = lk[0];
      for (int a = 0; a < 32; a++) begin
        put(1'b0, 16'hFFFF);
        put(1'b1, 16'h2000 | 16'(a));
        get(1'b0, r); chk(tag_of(a, lk[0]), r, merge_exp(a, model[a], lk[0]));
        get(1'b1, r); chk("R3 ctl after read", r, 16'hA000 | 16'(a));
      end
    end

    link_up = 1'b0;
    put(1'b0, 16'h1234);
    get(1'b1, r); chk("R2 ctl untouched", r, 16'hA01F);
    get(1'b0, r); chk("R2 data staged", r, 16'h1234);
    put(1'b0, 16'hBEEF);
    put(1'b1, 16'h1F03);
    get(1'b1, r); chk("R9 ctl as written", r, 16'h1F03);
    get(1'b0, r); chk("R9 data kept", r, 16'hBEEF);
    put(1'b1, 16'h2003);
    get(1'b0, r); chk("R9 bank unchanged", r, model[3]);

    link_up = 1'b1;
    put(1'b0, 16'h0000);
    put(1'b1, 16'h6001);
    model[1] = model[1] | 16'h0024;
    get(1'b0, r); chk("R10 read part", r, model[1]);
    get(1'b1, r); chk("R10 ctl", r, 16'hE001);
    link_up = 1'b0;
    put(1'b1, 16'h2001);
    get(1'b0, r); chk("R10 stored back", r, model[1]);

    put(1'b0, 16'hFFFE);
    put(1'b1, 16'h4000);
    put(1'b1, 16'h2000);
    get(1'b0, r); chk("R8 reset bit cleared", r, 16'h7FFF);

    get(1'b0, held);
    put(1'b0, 16'h0F0F);
    chk("R11 hold after write", bus_rdata, held);
    repeat (3) @(negedge clk);
    chk("R11 hold idle", bus_rdata, held);
    get(1'b0, r); chk("R11 fresh read", r, 16'h0F0F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule